// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Detection

The block is a general-purpose I/O controller for sixteen pins behind a 32-bit memory-mapped register port. Software writes an output data word and a direction word, and reads back the pin levels after they have passed through a two-flop synchroniser. A 1 in the direction word makes a line an input, and a 0 enables its output driver. The design drives `pin_oe` as the complement of the direction word.

Every line has its own event detector. The detector is set by a 3-bit style code and can fire on a high level, a low level, a rising edge, a falling edge or any edge. A detected event sets a sticky pending bit. Software clears a pending bit by writing a 1 to it. Lines 0 to 12 each drive an active-high interrupt output equal to their pending bit, for use by a parent interrupt controller. Lines 13 to 15 have pending bits but no interrupt output.

Bus accesses last one cycle: `bus_valid` together with `bus_write` selects a write or a read. Read data is registered and appears on the clock edge that follows the request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output data word, pending bits and style fields are zero, the direction word is 0x0000FFFF (every line an input, so `pin_oe` is 0), and `irq` is 0.
- R2: A write to offset 0x00 stores output data bits 15:0. The stored word drives `pin_out` and reads back from 0x00.
- R3: A write to offset 0x04 stores the direction word, where 1 means input. `pin_oe[i]` is the inverse of direction bit i, and the word reads back from 0x04.
- R4: Offset 0x08 returns the pin levels after two synchroniser flops, whatever the direction. A pin change appears there two clock edges later, and writes to 0x08 have no effect.
- R5: The style field of line i (3 bits) sits at bit i*3 of offset 0x10 for lines 0–7. For lines 8–15 it sits at bit (i-8)*3 of offset 0x14. Bits 31:24 of both registers read as zero.
- R6: Style 0 sets the pending bit on every cycle the synchronised pin is 1, and style 1 on every cycle it is 0. A cleared bit therefore sets again while the level lasts.
- R7: Style 2 fires when the synchronised pin changes 0→1 from one cycle to the next, style 3 on 1→0, and style 4 on either change.
- R8: Style codes 5, 6 and 7 never set a pending bit.
- R9: Offset 0x0C reads the pending bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: When a detection and a write-1 clear hit the same line in the same cycle, the pending bit ends up set.
- R11: `irq[i]` equals pending bit i for lines 0–12. Pending bits of lines 13–15 reach no output.
- R12: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read as zero, and writes to them change nothing. This includes 0x18 and 0x1C.
- R13: Read data is registered on the edge that accepts a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Raw pin levels (asynchronous) |
| pin_out | output | 16 | Output data toward the pads |
| pin_oe | output | 16 | Output driver enable, 1 = drive |
| irq | output | 13 | Active-high interrupt, lines 0–12 |

## Verification
The key collision is a detection event and a write-1 clear landing on the same pending bit in the same cycle.

The bench provokes it in two ways:
- It holds a level-style line active while clearing it.
- It changes an edge-style pin and issues the clear write exactly two edges later, the cycle in which the synchronised edge is seen.

A behavioural model with its own pipeline of pin samples predicts the pending word every cycle. Directed reads of the status register confirm that the bit survives the clear in both cases.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int STY_W = 3;

   typedef enum logic [STY_W-1:0] {
      STY_HIGH = 3'd0,
      STY_LOW  = 3'd1,
      STY_RISE = 3'd2,
      STY_FALL = 3'd3,
      STY_ANY  = 3'd4
   } gpio_style_e;

   localparam logic [7:0] OFF_OUT  = 8'h00;
   localparam logic [7:0] OFF_DIR  = 8'h04;
   localparam logic [7:0] OFF_IN   = 8'h08;
   localparam logic [7:0] OFF_STAT = 8'h0C;
   localparam logic [7:0] OFF_STY0 = 8'h10;
   localparam logic [7:0] OFF_STY1 = 8'h14;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    stg[s] <= '0;
         else if (s == 0) stg[s] <= d;
         else           stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_line_det.sv
module gpio_line_det
   import gpio_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sty_we,
   input  logic [STY_W-1:0] sty_wdata,
   input  logic             cur,
   input  logic             clr,
   output logic [STY_W-1:0] sty,
   output logic             evt,
   output logic             pend
);
   logic prev;

   always_comb begin
      unique case (sty)
         STY_HIGH: evt = cur;
         STY_LOW:  evt = ~cur;
         STY_RISE: evt = cur & ~prev;
         STY_FALL: evt = ~cur & prev;
         STY_ANY:  evt = cur ^ prev;
         default:  evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         sty  <= '0;
         pend <= 1'b0;
      end else begin
         prev <= cur;
         if (sty_we) sty <= sty_wdata;
         pend <= (pend & ~clr) | evt;
      end
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int IRQ_LINES   = 13,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe,
   output logic [IRQ_LINES-1:0] irq
);
   localparam int LINES_PER_REG = 8;
   localparam int STY_BITS      = LINES_PER_REG * STY_W;

   if (NUM_LINES < 1 || NUM_LINES > 2 * LINES_PER_REG) begin : g_bad_lines
      $error("NUM_LINES must be 1..16");
   end
   if (IRQ_LINES < 1 || IRQ_LINES > NUM_LINES) begin : g_bad_irq
      $error("IRQ_LINES must be 1..NUM_LINES");
   end
   if (DATA_W < STY_BITS || DATA_W < NUM_LINES) begin : g_bad_data
      $error("DATA_W too narrow for style fields");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x14");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                       wr, rd;
   logic                       hit_out, hit_dir, hit_in, hit_stat, hit_sty0, hit_sty1;
   logic [NUM_LINES-1:0]       out_q, dir_q, pin_sync, pend, evt, clr;
   logic [NUM_LINES*STY_W-1:0] sty_flat;
   logic [DATA_W-1:0]          sty_lo, sty_hi, rd_mux;
   logic                       unused_wdata;

   assign wr       = bus_valid & bus_write;
   assign rd       = bus_valid & ~bus_write;
   assign hit_out  = (bus_addr == ADDR_W'(OFF_OUT));
   assign hit_dir  = (bus_addr == ADDR_W'(OFF_DIR));
   assign hit_in   = (bus_addr == ADDR_W'(OFF_IN));
   assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
   assign hit_sty0 = (bus_addr == ADDR_W'(OFF_STY0));
   assign hit_sty1 = (bus_addr == ADDR_W'(OFF_STY1));
   assign unused_wdata = ^bus_wdata;

   assign clr = (wr && hit_stat) ? bus_wdata[NUM_LINES-1:0] : '0;

   gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '1;
      end else if (wr) begin
         if (hit_out) out_q <= bus_wdata[NUM_LINES-1:0];
         if (hit_dir) dir_q <= bus_wdata[NUM_LINES-1:0];
      end
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      localparam int REG = i / LINES_PER_REG;
      localparam int LSB = (i % LINES_PER_REG) * STY_W;
      logic sty_we;
      assign sty_we = wr && ((REG == 0) ? hit_sty0 : hit_sty1);

      gpio_line_det u_det (
         .clk       (clk),
         .rst_n     (rst_n),
         .sty_we    (sty_we),
         .sty_wdata (bus_wdata[LSB +: STY_W]),
         .cur       (pin_sync[i]),
         .clr       (clr[i]),
         .sty       (sty_flat[i*STY_W +: STY_W]),
         .evt       (evt[i]),
         .pend      (pend[i])
      );
   end

   always_comb begin
      sty_lo = '0;
      sty_hi = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (i < LINES_PER_REG)
            sty_lo[(i % LINES_PER_REG)*STY_W +: STY_W] = sty_flat[i*STY_W +: STY_W];
         else
            sty_hi[(i % LINES_PER_REG)*STY_W +: STY_W] = sty_flat[i*STY_W +: STY_W];
      end
      rd_mux = '0;
      if (hit_out)  rd_mux = DATA_W'(out_q);
      if (hit_dir)  rd_mux = DATA_W'(dir_q);
      if (hit_in)   rd_mux = DATA_W'(pin_sync);
      if (hit_stat) rd_mux = DATA_W'(pend);
      if (hit_sty0) rd_mux = sty_lo;
      if (hit_sty1) rd_mux = sty_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bus_rdata <= '0;
      else if (rd) bus_rdata <= rd_mux;
   end

   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;
   assign irq     = pend[IRQ_LINES-1:0];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int IRQ_LINES   = 13,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_valid,
   input logic                 bus_write,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic [NUM_LINES-1:0] pin_in,
   input logic [NUM_LINES-1:0] pin_out,
   input logic [NUM_LINES-1:0] pin_oe,
   input logic [IRQ_LINES-1:0] irq,
   input logic [NUM_LINES-1:0] pin_sync,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] evt
);
   logic                 wr_stat, wr_unmapped, mapped;
   logic [NUM_LINES-1:0] clr_m;
   logic [1:0]           age;
   logic                 unused_chk;

   assign unused_chk = ^{bus_wdata, pin_in};
   assign mapped = (bus_addr == ADDR_W'(OFF_OUT))  || (bus_addr == ADDR_W'(OFF_DIR))  ||
                   (bus_addr == ADDR_W'(OFF_IN))   || (bus_addr == ADDR_W'(OFF_STAT)) ||
                   (bus_addr == ADDR_W'(OFF_STY0)) || (bus_addr == ADDR_W'(OFF_STY1));
   assign wr_stat     = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_STAT));
   assign wr_unmapped = bus_valid && bus_write && !mapped;
   assign clr_m       = wr_stat ? bus_wdata[NUM_LINES-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && irq == '0 && pin_out == '0)); // R1

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend) & ~pend & ~$past(clr_m)) == '0)); // R9

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt) & ~pend) == '0)); // R10

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R13

   AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_unmapped |=> ($stable(pin_out) && $stable(pin_oe))); // R12

   if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
         (age == 2'd3) |-> (pin_sync == $past(pin_in, 2))); // R4
   end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .NUM_LINES(NUM_LINES), .IRQ_LINES(IRQ_LINES), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
   .pin_sync(pin_sync), .pend(pend), .evt(evt)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;
   logic [12:0] irq;

   int    n_cmp = 0, n_bad = 0;
   bit    cmp_en = 1'b0, done = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   gpio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // behavioural reference model
   logic [15:0] m_s1, m_s2, m_prev, m_pend, m_out, m_dir, m_ev, m_clr;
   logic [2:0]  m_sty [16];
   logic [31:0] m_rdata;

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [31:0] v;
      v = '0;
      case (a)
         8'h00: v = {16'h0, m_out};
         8'h04: v = {16'h0, m_dir};
         8'h08: v = {16'h0, m_s2};
         8'h0C: v = {16'h0, m_pend};
         8'h10: for (int i = 0; i < 8; i++) v[i*3 +: 3] = m_sty[i];
         8'h14: for (int i = 0; i < 8; i++) v[i*3 +: 3] = m_sty[i+8];
         default: v = '0;
      endcase
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_out = '0;
         m_dir = 16'hFFFF; m_rdata = '0;
         for (int i = 0; i < 16; i++) m_sty[i] = 3'd0;
      end else begin
         for (int i = 0; i < 16; i++) begin
            case (m_sty[i])
               3'd0: m_ev[i] = m_s2[i];
               3'd1: m_ev[i] = !m_s2[i];
               3'd2: m_ev[i] = m_s2[i] && !m_prev[i];
               3'd3: m_ev[i] = !m_s2[i] && m_prev[i];
               3'd4: m_ev[i] = m_s2[i] != m_prev[i];
               default: m_ev[i] = 1'b0;
            endcase
         end
         m_clr = (bus_valid && bus_write && bus_addr == 8'h0C) ? bus_wdata[15:0] : '0;
         if (bus_valid && !bus_write) m_rdata = m_read(bus_addr);
         if (bus_valid && bus_write) begin
            case (bus_addr)
               8'h00: m_out = bus_wdata[15:0];
               8'h04: m_dir = bus_wdata[15:0];
               8'h10: for (int i = 0; i < 8; i++) m_sty[i] = bus_wdata[i*3 +: 3];
               8'h14: for (int i = 0; i < 8; i++) m_sty[i+8] = bus_wdata[i*3 +: 3];
               default: ;
            endcase
         end
         m_pend = (m_pend & ~m_clr) | m_ev;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         n_cmp++;
         if (pin_out !== m_out) begin
            n_bad++; $display("FAIL R2 pin_out actual=%h expected=%h", pin_out, m_out);
         end
         if (pin_oe !== ~m_dir) begin
            n_bad++; $display("FAIL R3 pin_oe actual=%h expected=%h", pin_oe, ~m_dir);
         end
         if (irq !== m_pend[12:0]) begin
            n_bad++; $display("FAIL %s/R11 irq actual=%h expected=%h", cur_req, irq, m_pend[12:0]);
         end
         if (bus_rdata !== m_rdata) begin
            n_bad++; $display("FAIL %s/R13 rdata actual=%h expected=%h", cur_req, bus_rdata, m_rdata);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      chk(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   task automatic pins(input logic [15:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      // R1 reset state
      chk(pin_oe === 16'h0, "R1 pin_oe", {16'h0, pin_oe}, 32'h0);
      chk(irq === 13'h0, "R1 irq", {19'h0, irq}, 32'h0);
      rd(8'h04, 32'h0000FFFF, "R1 dir");
      rd(8'h0C, 32'h0, "R1 status");
      rd(8'h10, 32'h0, "R1 style");
      // R2 output data
      cur_req = "R2";
      wr(8'h00, 32'h0000A5C3);
      rd(8'h00, 32'h0000A5C3, "R2 readback");
      chk(pin_out === 16'hA5C3, "R2 pin_out", {16'h0, pin_out}, 32'hA5C3);
      // R3 direction
      cur_req = "R3";
      wr(8'h04, 32'h000000F0);
      chk(pin_oe === 16'hFF0F, "R3 pin_oe", {16'h0, pin_oe}, 32'hFF0F);
      rd(8'h04, 32'h000000F0, "R3 readback");
      // R5 style layout, R8 reserved codes
      cur_req = "R5";
      wr(8'h10, 32'hFFFFFFFF);
      wr(8'h14, 32'hFFFFFFFF);
      rd(8'h10, 32'h00FFFFFF, "R5 style lo");
      // R4 input register
      cur_req = "R4";
      pins(16'h1234);
      idle(3);
      rd(8'h08, 32'h00001234, "R4 input");
      wr(8'h08, 32'h0000FFFF);
      rd(8'h08, 32'h00001234, "R4 input write ignored");
      cur_req = "R8";
      pins(16'h0000); idle(3); pins(16'hFFFF); idle(3);
      rd(8'h0C, 32'h0, "R8 reserved styles");
      // R7 falling on lines 8-15, R11 irq map
      cur_req = "R7";
      wr(8'h14, 32'h5A6DB6DB);
      rd(8'h14, 32'h006DB6DB, "R5 style hi");
      wr(8'h0C, 32'h0000FFFF);
      pins(16'h00FF);
      idle(4);
      rd(8'h0C, 32'h0000FF00, "R7 falling");
      cur_req = "R11";
      chk(irq === 13'h1F00, "R11 irq", {19'h0, irq}, 32'h1F00);
      // R9 write-1 clear
      cur_req = "R9";
      wr(8'h0C, 32'h00000F00);
      rd(8'h0C, 32'h0000F000, "R9 partial clear");
      // R6 levels; lines 0..4 styles 0,1,2,3,4
      cur_req = "R6";
      wr(8'h10, 32'h00FFC688);
      wr(8'h0C, 32'h0000FFFF);
      rd(8'h0C, 32'h00000001, "R6 high level re-sets");
      pins(16'h00FE); idle(4);
      wr(8'h0C, 32'h0000FFFF);
      rd(8'h0C, 32'h0, "R6 level gone");
      pins(16'h00FC); idle(4);
      rd(8'h0C, 32'h00000002, "R6 low level");
      // R7 edges
      cur_req = "R7";
      wr(8'h0C, 32'h0000FFFF);
      pins(16'h00F8); idle(4);
      rd(8'h0C, 32'h00000002, "R7 rise ignores fall");
      pins(16'h00FC); idle(4);
      rd(8'h0C, 32'h00000006, "R7 rising");
      pins(16'h00F4); idle(4);
      rd(8'h0C, 32'h0000000E, "R7 falling");
      pins(16'h00E4); idle(4);
      rd(8'h0C, 32'h0000001E, "R7 any edge fall");
      wr(8'h0C, 32'h0000FFFF);
      pins(16'h00F4); idle(4);
      rd(8'h0C, 32'h00000012, "R7 any edge rise");
      // R10 edge event meets clear in the same cycle
      cur_req = "R10";
      wr(8'h0C, 32'h0000FFFF);
      rd(8'h0C, 32'h00000002, "R10 pre-clear");
      pins(16'h00E4);
      idle(1);
      wr(8'h0C, 32'h0000FFFF);
      rd(8'h0C, 32'h00000012, "R10 event beats clear");
      // R12 unmapped offsets
      cur_req = "R12";
      wr(8'h18, 32'hFFFFFFFF);
      wr(8'h1C, 32'hFFFFFFFF);
      wr(8'h20, 32'hFFFFFFFF);
      rd(8'h18, 32'h0, "R12 clock ctl");
      rd(8'h1C, 32'h0, "R12 debounce");
      rd(8'h20, 32'h0, "R12 other");
      rd(8'h00, 32'h0000A5C3, "R12 out intact");
      rd(8'h04, 32'h000000F0, "R12 dir intact");
      idle(2);
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end
endmodule